// File: doc/BRIEF.md
# Per-Lane Entropy Health Monitor

This block watches a 4-lane stream of raw random bits and runs two continuous health checks on every lane at once: a repetition check that flags a lane stuck on one value for too long, and a proportion check that flags a lane whose value is too lopsided over a fixed window of samples. Each lane is tested on its own, using bit i of the sample word only. Software sets the limit for each check through two cutoff inputs.

Whenever any check fails on any lane, the block raises a hold output that stops the downstream collector from taking more bits. The hold is not permanent. It drops by itself once one whole proportion window has gone by with no failure on any lane. For each failing sample the block also reports which lanes failed, with separate lane masks for the two checks. Clearing the enable stops all testing and returns every counter to zero.

Top module: `lane_health_mon`

## Requirements
- R1: For each lane the repetition check counts the run of identical accepted bits. The first accepted bit after enable starts a run of 1. When the run length after an accepted sample is at or above the repetition cutoff, bit i of `rep_event_o` is high for the cycle that follows that clock edge. This repeats for every further identical sample.
- R2: The proportion check splits accepted samples into windows of WIN_LEN samples, 512 by default. Windows start at the first sample after enable. In each lane the first bit of a window is the reference, and that bit counts as 1. Bit i of `prop_event_o` is high for one cycle right after the sample on which the lane's reference count reaches the proportion cutoff exactly. This happens at most once per window per lane.
- R3: Lane i looks only at `sample_i[i]` and reports only on bit i of each event mask. Lanes do not affect each other.
- R4: `hold_o` goes high in the cycle after any accepted sample that raises an event on any lane.
- R5: `hold_o` goes low on the clock edge that accepts the last sample of a window in which no lane failed. The window in which a failure happens never releases the hold.
- R6: A sample is accepted only on a clock edge where `sample_valid_i` and `enable_i` are both high. Samples that are not accepted change no count and raise no event.
- R7: A cutoff value of zero turns off the matching check. That check never raises an event.
- R8: While `enable_i` is low, all run counts, reference counts and window positions are zero. `hold_o` and both event masks are low from the next cycle on. After re-enable, testing starts with a fresh run and a fresh window.
- R9: After reset, `hold_o`, `rep_event_o` and `prop_event_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Turns testing on; low clears all state |
| sample_valid_i | input | 1 | Marks `sample_i` as a new sample this cycle |
| sample_i | input | LANES | One raw bit per lane |
| rep_cutoff_i | input | CNT_W | Repetition cutoff (0 turns the check off) |
| prop_cutoff_i | input | CNT_W | Proportion cutoff (0 turns the check off) |
| hold_o | output | 1 | Stops downstream collection while the stream is unhealthy |
| rep_event_o | output | LANES | Lanes whose repetition check failed on the last sample |
| prop_event_o | output | LANES | Lanes whose proportion check failed on the last sample |

## Verification
The bench sends a short mixed sequence in which each lane's run starts and ends on a different sample, so a design that mixes up lanes, or counts a run from 0 instead of 1, reports the wrong lane mask. It holds the hold through the rest of the failing window and through the whole next clean window, checking just before and just after the last sample. A design that releases on the first clean window edge, or never releases, fails that check. It also checks four other cases: idle cycles with a repeated bit on the input, whose events would show if an unaccepted sample were counted; a disable and re-enable in the middle of a run, which must restart the count; a stuck stream with both cutoffs at zero; and a two-window stuck stream, which must give exactly one proportion event per window.

// File: rtl/lane_health_pkg.sv
package lane_health_pkg;
   localparam int unsigned DEF_LANES   = 4;
   localparam int unsigned DEF_WIN_LEN = 512;

   // Counter width able to hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return $clog2(max_val + 1);
   endfunction

   typedef enum logic [1:0] {
      WIN_FIRST = 2'd0,
      WIN_MID   = 2'd1,
      WIN_LAST  = 2'd2
   } win_phase_e;
endpackage

// File: rtl/lhm_rep_lane.sv
module lhm_rep_lane #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             take_i,
   input  logic             bit_i,
   input  logic [CNT_W-1:0] cutoff_i,
   output logic             fail_o,
   output logic             event_o
);
   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

   logic             prev_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_nx;
   logic             same_c;
   logic             ev_q;

   assign same_c = (run_q != '0) && (bit_i == prev_q);

   always_comb begin
      if (!same_c)
         run_nx = {{(CNT_W-1){1'b0}}, 1'b1};
      else if (run_q == RUN_MAX)
         run_nx = RUN_MAX;
      else
         run_nx = run_q + 1'b1;
   end

   assign fail_o  = take_i && (cutoff_i != '0) && (run_nx >= cutoff_i);
   assign event_o = ev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         run_q  <= '0;
         ev_q   <= 1'b0;
      end else if (!en_i) begin
         prev_q <= 1'b0;
         run_q  <= '0;
         ev_q   <= 1'b0;
      end else begin
         ev_q <= fail_o;
         if (take_i) begin
            prev_q <= bit_i;
            run_q  <= run_nx;
         end
      end
   end

   // R1
   run_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && same_c && run_q != RUN_MAX) |=> (run_q == $past(run_q) + 1'b1));

   // R7
   rep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cutoff_i == '0) |=> !ev_q);

   // R8
   rep_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (run_q == '0 && !ev_q));
endmodule

// File: rtl/lhm_prop_lane.sv
module lhm_prop_lane #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             take_i,
   input  logic             first_i,
   input  logic             bit_i,
   input  logic [CNT_W-1:0] cutoff_i,
   output logic             fail_o,
   output logic             event_o
);
   logic             ref_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             inc_c;
   logic             ev_q;

   assign inc_c = first_i || (bit_i == ref_q);

   always_comb begin
      if (first_i)
         cnt_nx = {{(CNT_W-1){1'b0}}, 1'b1};
      else if (inc_c)
         cnt_nx = cnt_q + 1'b1;
      else
         cnt_nx = cnt_q;
   end

   assign fail_o  = take_i && inc_c && (cutoff_i != '0) && (cnt_nx == cutoff_i);
   assign event_o = ev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= 1'b0;
         cnt_q <= '0;
         ev_q  <= 1'b0;
      end else if (!en_i) begin
         ref_q <= 1'b0;
         cnt_q <= '0;
         ev_q  <= 1'b0;
      end else begin
         ev_q <= fail_o;
         if (take_i) begin
            cnt_q <= cnt_nx;
            if (first_i) ref_q <= bit_i;
         end
      end
   end

   // R6
   prop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !take_i) |=> $stable(cnt_q));

   // R2
   prop_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && first_i) |=> (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}));

   // R7
   prop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cutoff_i == '0) |=> !ev_q);
endmodule

// File: rtl/lhm_window_ctl.sv
module lhm_window_ctl
   import lane_health_pkg::*;
#(
   parameter int unsigned WIN_LEN = 512
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic take_i,
   input  logic fail_any_i,
   output logic first_o,
   output logic hold_o
);
   localparam int unsigned POS_W = $clog2(WIN_LEN);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN_LEN - 1);

   logic [POS_W-1:0] pos_q;
   logic             dirty_q;
   logic             hold_q;
   win_phase_e       phase_c;

   always_comb begin
      if (pos_q == '0)
         phase_c = WIN_FIRST;
      else if (pos_q == POS_LAST)
         phase_c = WIN_LAST;
      else
         phase_c = WIN_MID;
   end

   assign first_o = (phase_c == WIN_FIRST);
   assign hold_o  = hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q   <= '0;
         dirty_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (!en_i) begin
         pos_q   <= '0;
         dirty_q <= 1'b0;
         hold_q  <= 1'b0;
      end else if (take_i) begin
         if (phase_c == WIN_LAST) begin
            pos_q   <= '0;
            dirty_q <= 1'b0;
            if (fail_any_i)
               hold_q <= 1'b1;
            else if (!dirty_q)
               hold_q <= 1'b0;
         end else begin
            pos_q <= pos_q + 1'b1;
            if (fail_any_i) begin
               dirty_q <= 1'b1;
               hold_q  <= 1'b1;
            end
         end
      end
   end

   // R4
   hold_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && fail_any_i) |=> hold_q);

   // R5
   hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_q && en_i && !(take_i && phase_c == WIN_LAST)) |=> hold_q);

   // R8
   hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!hold_q && pos_q == '0));
endmodule

// File: rtl/lane_health_mon.sv
module lane_health_mon
   import lane_health_pkg::*;
#(
   parameter int unsigned LANES   = DEF_LANES,
   parameter int unsigned WIN_LEN = DEF_WIN_LEN,
   parameter int unsigned CNT_W   = cnt_width(DEF_WIN_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             sample_valid_i,
   input  logic [LANES-1:0] sample_i,
   input  logic [CNT_W-1:0] rep_cutoff_i,
   input  logic [CNT_W-1:0] prop_cutoff_i,
   output logic             hold_o,
   output logic [LANES-1:0] rep_event_o,
   output logic [LANES-1:0] prop_event_o
);
   localparam int unsigned MIN_CNT_W = cnt_width(WIN_LEN);

   if (LANES < 1) begin : g_bad_lanes
      $error("lane_health_mon: LANES must be at least 1");
   end
   if (WIN_LEN < 2 || (WIN_LEN & (WIN_LEN - 1)) != 0) begin : g_bad_win
      $error("lane_health_mon: WIN_LEN must be a power of two, at least 2");
   end
   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("lane_health_mon: CNT_W too small to count a full window");
   end

   logic             take_c;
   logic             first_c;
   logic [LANES-1:0] rep_fail_c;
   logic [LANES-1:0] prop_fail_c;
   logic             fail_any_c;

   assign take_c     = enable_i && sample_valid_i;
   assign fail_any_c = (|rep_fail_c) || (|prop_fail_c);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lhm_rep_lane #(.CNT_W(CNT_W)) u_rep (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .en_i     (enable_i),
         .take_i   (take_c),
         .bit_i    (sample_i[i]),
         .cutoff_i (rep_cutoff_i),
         .fail_o   (rep_fail_c[i]),
         .event_o  (rep_event_o[i])
      );

      lhm_prop_lane #(.CNT_W(CNT_W)) u_prop (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .en_i     (enable_i),
         .take_i   (take_c),
         .first_i  (first_c),
         .bit_i    (sample_i[i]),
         .cutoff_i (prop_cutoff_i),
         .fail_o   (prop_fail_c[i]),
         .event_o  (prop_event_o[i])
      );
   end

   lhm_window_ctl #(.WIN_LEN(WIN_LEN)) u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (enable_i),
      .take_i     (take_c),
      .fail_any_i (fail_any_c),
      .first_o    (first_c),
      .hold_o     (hold_o)
   );

   // R6
   ev_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|rep_event_o) || (|prop_event_o)) |-> $past(take_c));

   // R4
   ev_implies_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|rep_event_o) || (|prop_event_o)) |-> hold_o);
endmodule

// File: tb/lane_health_mon_tb.sv
module lane_health_mon_tb_top;
   localparam int unsigned CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          valid = 1'b0;
   logic [3:0]    smp = '0;
   logic [CW-1:0] rep_cut = '0;
   logic [CW-1:0] prop_cut = '0;
   logic          hold;
   logic [3:0]    rep_ev;
   logic [3:0]    prop_ev;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lane_health_mon dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .enable_i       (en),
      .sample_valid_i (valid),
      .sample_i       (smp),
      .rep_cutoff_i   (rep_cut),
      .prop_cutoff_i  (prop_cut),
      .hold_o         (hold),
      .rep_event_o    (rep_ev),
      .prop_event_o   (prop_ev)
   );

   // {sample, expected repetition lane mask} with repetition cutoff 3
   localparam logic [7:0] VEC [9] = '{
      8'b0000_0000, 8'b0001_0000, 8'b0011_1100, 8'b0111_1001, 8'b1110_0010,
      8'b1010_0010, 8'b0101_0000, 8'b0101_0000, 8'b0101_1111
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] s);
      smp   = s;
      valid = 1'b1;
      @(posedge clk);
      #1;
      valid = 1'b0;
   endtask

   task automatic restart();
      en = 1'b0;
      @(posedge clk);
      #1;
      en = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int evcount;
      bit seen;
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      chk(hold == 1'b0 && rep_ev == 0 && prop_ev == 0, "R9", "reset outputs",
          {hold, rep_ev, prop_ev}, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1 R3 R4: table walk, repetition cutoff 3
      rep_cut = 10'd3;
      prop_cut = 10'd511;
      restart();
      seen = 1'b0;
      for (int i = 0; i < 9; i++) begin
         send(VEC[i][7:4]);
         if (VEC[i][3:0] != 0) seen = 1'b1;
         chk(rep_ev == VEC[i][3:0], "R1", "rep lane mask", rep_ev, VEC[i][3:0]);
         chk(prop_ev == 0, "R3", "no proportion event", prop_ev, 0);
         chk(hold == seen, "R4", "hold follows failures", hold, seen);
      end

      // R7 cutoffs of zero: a stuck stream raises nothing
      rep_cut = '0;
      prop_cut = '0;
      restart();
      evcount = 0;
      for (int i = 0; i < 600; i++) begin
         send(4'b0000);
         if (rep_ev != 0 || prop_ev != 0 || hold) evcount++;
      end
      chk(evcount == 0, "R7", "events with cutoffs zero", evcount, 0);

      // R2 proportion cutoff 10 reached on the 10th sample of window
      prop_cut = 10'd10;
      restart();
      for (int i = 0; i < 9; i++) send(4'b0000);
      chk(prop_ev == 0, "R2", "before cutoff", prop_ev, 0);
      send(4'b0000);
      chk(prop_ev == 4'b1111, "R2", "at cutoff", prop_ev, 15);
      chk(hold == 1'b1, "R4", "hold after proportion fail", hold, 1);
      send(4'b0000);
      chk(prop_ev == 0, "R2", "only once per window", prop_ev, 0);

      // R5 hold stays through failing window and the next clean window
      prop_cut = 10'd300;
      for (int i = 11; i < 1023; i++) send((i % 2) ? 4'b0101 : 4'b1010);
      chk(hold == 1'b1, "R5", "hold before clean window ends", hold, 1);
      send(4'b0101);
      chk(hold == 1'b0, "R5", "hold released after clean window", hold, 0);

      // R2 exactly one proportion event per window on a stuck lane
      prop_cut = 10'd10;
      restart();
      evcount = 0;
      for (int i = 0; i < 1024; i++) begin
         send(4'b1110);
         if (prop_ev[0]) evcount++;
      end
      chk(evcount == 2, "R2", "events over two windows", evcount, 2);

      // R8 disable clears and restarts the run
      prop_cut = '0;
      rep_cut = 10'd2;
      restart();
      send(4'b0000);
      send(4'b0000);
      chk(rep_ev == 4'b1111 && hold, "R8", "fail before disable", {hold, rep_ev}, 31);
      en = 1'b0;
      @(posedge clk);
      #1;
      chk(hold == 1'b0 && rep_ev == 0, "R8", "cleared by disable", {hold, rep_ev}, 0);
      en = 1'b1;
      send(4'b0000);
      chk(rep_ev == 0, "R8", "fresh run after enable", rep_ev, 0);
      send(4'b0000);
      chk(rep_ev == 4'b1111, "R8", "run counts again", rep_ev, 15);

      // R6 unaccepted samples are ignored
      rep_cut = 10'd3;
      restart();
      send(4'b0000);
      send(4'b0000);
      smp = 4'b0000;
      evcount = 0;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk);
         #1;
         if (rep_ev != 0 || hold) evcount++;
      end
      chk(evcount == 0, "R6", "idle cycles raise nothing", evcount, 0);
      send(4'b1111);
      chk(rep_ev == 0 && hold == 1'b0, "R6", "run not extended by idle", {hold, rep_ev}, 0);

      finish_run();
   end
endmodule